// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block holds a running clock and calendar in packed BCD. The fields are seconds, minutes, hours, day of week, date, month and a two-digit year. A base tick input feeds an internal prescaler, which produces one counting step per second. The whole chain ripples through the fields from that step: seconds, then minutes, then hours, then the day-level fields. Month lengths and leap years are handled. Hours can run in a 24-hour format or in a 12-hour format with an afternoon flag.

A host sets any field through a byte-wide write port. All seven bytes are always visible on parallel outputs. A halt flag in the seconds byte freezes timekeeping. Any write to the seconds byte restarts the prescaler. The result of writing an illogical value is undefined.

Field addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write to address 7 changes nothing.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the bank reads seconds 00, minutes 00, hours 00 (24-hour), day of week 01, date 01, month 01, year 00, with the halt flag clear.
- R2: Seconds and minutes count in BCD from 00 to 59. Passing 59 returns the field to 00 and carries into the next field.
- R3: Bit 7 of the seconds byte is the halt flag. While it is 1, no field and no prescaler state advances. It reads back as written.
- R4: With hours bit 6 at 0, hours count 00 to 23 in BCD, and bits 5:4 hold the tens digit. Stepping past 23:59:59 gives 00:00:00 and advances the day-level fields.
- R5: With hours bit 6 at 1, bit 5 is the afternoon flag and bits 4:0 count 01 to 12. 11:59:59 goes to 12:00:00 with the flag toggled. 12:59:59 goes to 01:00:00 with the flag kept. Only the afternoon-to-morning toggle advances the day-level fields.
- R6: Day of week counts 01 to 07 and wraps to 01. It steps at midnight, in the same cycle as the date.
- R7: The date returns to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months apart from 02.
- R8: February ends at 29 when the BCD year value is a multiple of 4 (year 00 included), and at 28 otherwise.
- R9: Month 12 rolls to 01 and carries into the year. The year counts 00 to 99 in BCD and wraps to 00.
- R10: A write to the seconds byte restarts the prescaler, so the next count comes a full PRESC_DIV base ticks later.
- R11: Bits with no meaning read as 0: bit 7 of minutes and hours, bits 7:3 of day of week, bits 7:6 of date, bits 7:5 of month.
- R12: If a host write hits a field in the same cycle as a carry into that field, the written value is kept and the carry goes no further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle pulse at PRESC_DIV times per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Field address of the write |
| wr_data | input | 8 | Byte to write |
| sec_q | output | 8 | Halt flag and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Mode, afternoon or tens-20 bit, and BCD hours |
| dow_q | output | 8 | Day of week 1 to 7 |
| date_q | output | 8 | BCD date |
| month_q | output | 8 | BCD month |
| year_q | output | 8 | BCD year |

## Verification
Some properties are checked on every cycle. A field held at its limit and given a step must return to its minimum. Fields must stay unchanged when nothing drives them. The hours mode bit changes only on a write. The afternoon flag toggles at eleven. A halted clock keeps every byte frozen. Day of week and date step together when no write is made. Month lengths, leap years, the twelve-hour sequence, masking of bits with no meaning, prescaler restart timing and write-over-carry priority can only be shown by the bench scenarios, which load a full date and time and compare all seven bytes after one second.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int BYTE_W     = 8;
   localparam int NUM_FIELDS = 7;

   typedef enum logic [2:0] {
      F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DOW = 3'd3,
      F_DATE = 3'd4, F_MONTH = 3'd5, F_YEAR = 3'd6
   } field_e;

   // one BCD step on a two-digit byte
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // multiple of 4 in BCD: even tens needs units 0/4/8, odd tens needs 2/6
   function automatic logic bcd_leap(input logic [7:0] yr);
      if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
      return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_tick,
   input  logic run,
   input  logic clear,
   output logic sec_tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("cal_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         logic unused_pass;
         assign unused_pass = clear ^ clk ^ rst_n;
         assign sec_tick    = base_tick & run;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         logic          at_end;
         assign at_end   = (cnt == CW'(DIV - 1));
         assign sec_tick = base_tick & run & at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (clear)            cnt <= '0;
            else if (base_tick && run) cnt <= at_end ? '0 : cnt + 1'b1;
         end

         assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (cnt == '0));
         assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clear) |=> $stable(cnt));
      end
   endgenerate
endmodule

// File: rtl/cal_wrap_digit.sv
module cal_wrap_digit import cal_pkg::*; #(
   parameter logic [7:0] MIN   = 8'h00,
   parameter logic [7:0] WMASK = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [BYTE_W-1:0] lim,
   input  logic             wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q,
   output logic             carry
);
   logic at_lim;
   assign at_lim = (q == lim);
   // a written field never passes a carry on (R12)
   assign carry  = inc & ~wr & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= MIN;
      else if (wr)  q <= wdata & WMASK;
      else if (inc) q <= at_lim ? MIN : bcd_inc(q);
   end

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && at_lim) |=> (q == MIN));
   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == ($past(wdata) & WMASK)));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr) |=> $stable(q));
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit import cal_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] q,
   output logic             carry
);
   logic [BYTE_W-1:0] nxt, stepped;
   logic              wrap_day;

   always_comb begin
      nxt      = q;
      wrap_day = 1'b0;
      stepped  = 8'h00;
      if (q[6]) begin
         stepped = bcd_inc({3'b000, q[4:0]});
         if (q[4:0] == 5'h11) begin
            nxt      = {2'b01, ~q[5], 5'h12};
            wrap_day = q[5];
         end else if (q[4:0] == 5'h12) begin
            nxt = {2'b01, q[5], 5'h01};
         end else begin
            nxt = {2'b01, q[5], stepped[4:0]};
         end
      end else begin
         stepped = bcd_inc({2'b00, q[5:0]});
         if (q[5:0] == 6'h23) begin
            nxt      = 8'h00;
            wrap_day = 1'b1;
         end else begin
            nxt = {2'b00, stepped[5:0]};
         end
      end
   end

   assign carry = inc & ~wr & wrap_day;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (wr)  q <= wdata & 8'h7F;
      else if (inc) q <= nxt;
   end

   assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q[6]));
   assert_pm_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && q[6] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5])));
   assert_midnight_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr && !q[6] && q[5:0] == 6'h23) |=> (q == 8'h00));
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core import cal_pkg::*; #(
   parameter int PRESC_DIV = 32768,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        sec_q,
   output logic [7:0]        min_q,
   output logic [7:0]        hour_q,
   output logic [7:0]        dow_q,
   output logic [7:0]        date_q,
   output logic [7:0]        month_q,
   output logic [7:0]        year_q
);
   localparam int NSEL = NUM_FIELDS;

   generate
      if ((1 << ADDR_W) < NSEL) begin : g_bad_addr
         $error("bcd_calendar_core: ADDR_W too narrow for the field bank");
      end
   endgenerate

   logic [NSEL-1:0] wsel;
   generate
      for (genvar f = 0; f < NSEL; f++) begin : g_dec
         assign wsel[f] = wr_en && (wr_addr == ADDR_W'(f));
      end
   endgenerate

   logic       halt;
   logic       sec_tick, c_sec, c_min, day_tick, c_date, c_month, c_year, c_dow;
   logic [7:0] sec_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          halt <= 1'b0;
      else if (wsel[F_SEC]) halt <= wr_data[7];
   end

   cal_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .run(~halt),
      .clear(wsel[F_SEC]), .sec_tick(sec_tick));

   cal_wrap_digit #(.MIN(8'h00), .WMASK(8'h7F)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(sec_tick), .lim(8'h59), .wr(wsel[F_SEC]),
      .wdata(wr_data), .q(sec_v), .carry(c_sec));

   cal_wrap_digit #(.MIN(8'h00), .WMASK(8'h7F)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .lim(8'h59), .wr(wsel[F_MIN]),
      .wdata(wr_data), .q(min_q), .carry(c_min));

   cal_hour_unit u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .wr(wsel[F_HOUR]),
      .wdata(wr_data), .q(hour_q), .carry(day_tick));

   cal_wrap_digit #(.MIN(8'h01), .WMASK(8'h07)) u_dow (
      .clk(clk), .rst_n(rst_n), .inc(day_tick), .lim(8'h07), .wr(wsel[F_DOW]),
      .wdata(wr_data), .q(dow_q), .carry(c_dow));

   cal_wrap_digit #(.MIN(8'h01), .WMASK(8'h3F)) u_date (
      .clk(clk), .rst_n(rst_n), .inc(day_tick), .lim(month_end(month_q, year_q)),
      .wr(wsel[F_DATE]), .wdata(wr_data), .q(date_q), .carry(c_date));

   cal_wrap_digit #(.MIN(8'h01), .WMASK(8'h1F)) u_month (
      .clk(clk), .rst_n(rst_n), .inc(c_date), .lim(8'h12), .wr(wsel[F_MONTH]),
      .wdata(wr_data), .q(month_q), .carry(c_month));

   cal_wrap_digit #(.MIN(8'h00), .WMASK(8'hFF)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(c_month), .lim(8'h99), .wr(wsel[F_YEAR]),
      .wdata(wr_data), .q(year_q), .carry(c_year));

   logic unused_carries;
   assign unused_carries = c_year ^ c_dow;

   assign sec_q = sec_v | {halt, 7'b0};

   assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
                            && $stable(date_q)));
   assert_dow_with_date_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(dow_q) == $stable(date_q)));
endmodule

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   bcd_calendar_core #(.PRESC_DIV(DIV), .ADDR_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q),
      .hour_q(hour_q), .dow_q(dow_q), .date_q(date_q), .month_q(month_q),
      .year_q(year_q));

   // bytes in order sec, min, hour, dow, date, month, year
   typedef struct packed {
      logic [15:0] req;
      logic [55:0] init;
      logic [55:0] expv;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{"R2", 56'h58000001010124, 56'h59000001010124},
      '{"R2", 56'h59591002050324, 56'h00001102050324},
      '{"R6", 56'h59592307150624, 56'h00000001160624},
      '{"R7", 56'h59592303300424, 56'h00000004010524},
      '{"R7", 56'h59592303310123, 56'h00000004010223},
      '{"R7", 56'h59592303300123, 56'h00000004310123},
      '{"R8", 56'h59592301280223, 56'h00000002010323},
      '{"R8", 56'h59592301280224, 56'h00000002290224},
      '{"R8", 56'h59592301280200, 56'h00000002290200},
      '{"R8", 56'h59592301290296, 56'h00000002010396},
      '{"R9", 56'h59592305311299, 56'h00000006010100},
      '{"R9", 56'h59592305311219, 56'h00000006010120},
      '{"R5", 56'h59595102100524, 56'h00007202100524},
      '{"R5", 56'h59597102100524, 56'h00005203110524},
      '{"R5", 56'h59597204100524, 56'h00006104100524},
      '{"R4", 56'h59590904100524, 56'h00001004100524}
   };

   task automatic chk(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [55:0] e);
      chk(req, "sec",   sec_q,   e[55:48]);
      chk(req, "min",   min_q,   e[47:40]);
      chk(req, "hour",  hour_q,  e[39:32]);
      chk(req, "dow",   dow_q,   e[31:24]);
      chk(req, "date",  date_q,  e[23:16]);
      chk(req, "month", month_q, e[15:8]);
      chk(req, "year",  year_q,  e[7:0]);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         base_tick = 1'b1;
         @(negedge clk);
         base_tick = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset contents
      chk_all("R1", 56'h00000001010100);

      // table walk: load every field, let one second pass, compare all bytes
      for (int v = 0; v < NV; v++) begin
         for (int f = 0; f < 7; f++) wr(3'(f), VECS[v].init[55 - 8*f -: 8]);
         pulses(DIV);
         chk_all(string'(VECS[v].req), VECS[v].expv);
      end

      // R3: halt freezes everything and reads back in bit 7
      wr(3'd2, 8'h08); wr(3'd1, 8'h15);
      wr(3'd0, 8'h90);
      pulses(2 * DIV);
      chk("R3", "sec halted", sec_q, 8'h90);
      chk("R3", "min halted", min_q, 8'h15);
      wr(3'd0, 8'h10);
      pulses(DIV);
      chk("R3", "sec resumed", sec_q, 8'h11);

      // R10: seconds write restarts the prescaler
      wr(3'd0, 8'h20);
      pulses(2);
      wr(3'd0, 8'h40);
      pulses(DIV - 1);
      chk("R10", "no step yet", sec_q, 8'h40);
      pulses(1);
      chk("R10", "step after full second", sec_q, 8'h41);

      // R11: meaningless bits masked, address 7 ignored
      wr(3'd1, 8'hA5); chk("R11", "min mask", min_q, 8'h25);
      wr(3'd2, 8'h85); chk("R11", "hour mask", hour_q, 8'h05);
      wr(3'd3, 8'hF3); chk("R11", "dow mask", dow_q, 8'h03);
      wr(3'd4, 8'hC7); chk("R11", "date mask", date_q, 8'h07);
      wr(3'd5, 8'hE9); chk("R11", "month mask", month_q, 8'h09);
      wr(3'd7, 8'h33);
      chk_all("R11", 56'h41250503070900 | {48'h0, year_q});

      // R12: carry into minutes collides with a minutes write
      wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h05);
      pulses(DIV - 1);
      @(negedge clk);
      base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
      @(negedge clk);
      base_tick = 1'b0; wr_en = 1'b0;
      chk("R12", "sec wrapped", sec_q, 8'h00);
      chk("R12", "min from write", min_q, 8'h30);
      chk("R12", "hour not carried", hour_q, 8'h05);

      finish_run();
   end
endmodule